// File: doc/BRIEF.md
# Fixed-Period Pulse-Width Modulator with Releasable Output

This block is a register-controlled pulse-width modulator with a fixed period. A free-running step counter advances once for every pulse on a tick input. The tick is produced elsewhere from the system clock so that 256 steps span 1 ms. The counter wraps after 256 steps and is compared against an 8-bit duty code. The compare result is gated by an enable bit to form the output pin value. The pin has a data line and an output-enable line. When the block is disabled, the pin is released to high impedance and is not driven low.

Software reaches the block through a small register port. A write strobe carries an address and a byte, and a combinational read returns the byte at the addressed location. The duty code sits at address 0xD8. The enable is bit 7 of the control byte at address 0xD2, and the other seven bits of that byte are plain storage. Register writes act on the pin straight away, with no shadow copy and no wait for a period boundary. A change made in the middle of a period can therefore cut a pulse short or add a pulse to that period. The lowest duty code still gives one step of high time, so a 0% duty cycle cannot be produced.

Top module: `fixperiod_pwm`

## Requirements
- R1: The step counter advances by one on each clock edge where tickIn is high and holds otherwise. It wraps from 255 to 0, and register writes never reset or stall it.
- R2: While enabled, pinData is 1 when the step count is less than or equal to the duty code and 0 otherwise. The high time per period is therefore (duty code + 1) steps out of 256.
- R3: Duty code 0 gives exactly one high step per period and duty code 255 gives a constant high, so an enabled output is never low for a whole period.
- R4: A write to address 0xD8 changes the duty code seen by the compare in the cycle after the write edge, at any point within the period.
- R5: Writing the control byte at 0xD2 with bit 7 set makes pinOe 1 from the cycle after the write.
- R6: Writing the control byte with bit 7 clear makes pinOe 0 and pinData 0 from the cycle after the write, which releases the pin.
- R7: Bits 6..0 of the control byte are stored and read back unchanged, and have no effect on pinOe or pinData.
- R8: A read at 0xD8 returns the duty code and a read at 0xD2 returns the control byte. A read at any other address returns 0, and a write to any other address changes nothing.
- R9: Reset sets the step count to 0, the duty code to 0 and the control byte to 0, so the pin starts released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | One-cycle step pulse, 256 pulses per 1 ms period |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for reads and writes |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data at regAddr, combinational |
| pinData | output | 1 | Pin output value |
| pinOe | output | 1 | Pin output enable; 0 releases the pin |

## Verification
The compare is tried with fixed duty codes 0, 127 and 255 over whole periods, counting the high steps in each. These runs separate an off-by-one in the compare from an error in the wrap point. Mid-period duty rewrites are made on both sides of the current count, which shows whether a write acts at once or waits for the period boundary. A long random mix of ticks, duty writes, control writes with random upper and lower bits, and stray addresses is checked every cycle against a bench model. That mix exposes any leak from the storage-only control bits into the pin and any decode that accepts a wrong address.

// File: rtl/fixperiod_pwm_pkg.sv
package fixperiod_pwm_pkg;
  localparam int PWM_W = 8;
  localparam int STEPS = 1 << PWM_W;

  typedef struct packed {
    logic             dutyLoad;
    logic [PWM_W-1:0] dutyVal;
    logic             outEnable;
  } pwm_strobe_t;
endpackage

// File: rtl/fixperiod_pwm_ctrl.sv
module fixperiod_pwm_ctrl
  import fixperiod_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DUTY_ADDR = 8'hD8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD2,
  parameter int EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PWM_W-1:0]  wrData,
  input  logic [PWM_W-1:0]  dutyIn,
  output logic [PWM_W-1:0]  rdData,
  output pwm_strobe_t       strobe
);
  logic [PWM_W-1:0] ctrlReg;
  logic hitDuty, hitCtrl;

  assign hitDuty = (regAddr == DUTY_ADDR);
  assign hitCtrl = (regAddr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrEn && hitCtrl) ctrlReg <= wrData;
  end

  always_comb begin
    strobe.dutyLoad  = wrEn && hitDuty;
    strobe.dutyVal   = wrData;
    strobe.outEnable = ctrlReg[EN_BIT];
  end

  always_comb begin
    if (hitDuty) rdData = dutyIn;
    else if (hitCtrl) rdData = ctrlReg;
    else rdData = '0;
  end

  // R5: setting the enable bit turns on output drive next cycle
  assert_enable_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitCtrl && wrData[EN_BIT]) |=> strobe.outEnable);

  // R6: clearing the enable bit releases the pin next cycle
  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitCtrl && !wrData[EN_BIT]) |=> !strobe.outEnable);

  // R8: control byte is untouched when no control write occurs
  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && hitCtrl) |=> $stable(ctrlReg));
endmodule

// File: rtl/fixperiod_pwm_dp.sv
module fixperiod_pwm_dp
  import fixperiod_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  pwm_strobe_t      strobe,
  output logic [PWM_W-1:0] dutyOut,
  output logic             pinData,
  output logic             pinOe
);
  localparam logic [PWM_W-1:0] LAST_STEP = PWM_W'(STEPS - 1);

  logic [PWM_W-1:0] stepCnt;
  logic [PWM_W-1:0] dutyReg;
  logic             cmpHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepCnt <= '0;
    else if (tickIn) stepCnt <= stepCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dutyReg <= '0;
    else if (strobe.dutyLoad) dutyReg <= strobe.dutyVal;
  end

  assign cmpHigh = (stepCnt <= dutyReg);
  assign pinOe   = strobe.outEnable;
  assign pinData = strobe.outEnable & cmpHigh;
  assign dutyOut = dutyReg;

  // R1: counter wraps to zero after the last step
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && stepCnt == LAST_STEP) |=> (stepCnt == '0));

  // R1: no tick, no movement, whatever is written
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> $stable(stepCnt));

  // R3: enabled output is high at step zero for every duty code
  assert_min_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && stepCnt == '0) |-> pinData);

  // R3: full-scale duty code keeps the output high
  assert_full_scale_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && dutyReg == LAST_STEP) |-> pinData);

  // R4: duty write reaches the compare on the next cycle
  assert_duty_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dutyLoad |=> (dutyReg == $past(strobe.dutyVal)));

  // R6: a released pin carries no data
  assert_released_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe |-> !pinData);
endmodule

// File: rtl/fixperiod_pwm.sv
module fixperiod_pwm
  import fixperiod_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DUTY_ADDR = 8'hD8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD2,
  parameter int EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PWM_W-1:0]  wrData,
  output logic [PWM_W-1:0]  rdData,
  output logic              pinData,
  output logic              pinOe
);
  pwm_strobe_t      strobe;
  logic [PWM_W-1:0] dutyNow;

  fixperiod_pwm_ctrl #(
    .ADDR_W(ADDR_W), .DUTY_ADDR(DUTY_ADDR), .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .dutyIn(dutyNow), .rdData(rdData), .strobe(strobe)
  );

  fixperiod_pwm_dp i_dp (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .strobe(strobe),
    .dutyOut(dutyNow), .pinData(pinData), .pinOe(pinOe)
  );
endmodule

// File: tb/test_fixperiod_pwm.sv
module test_fixperiod_pwm;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic pinData, pinOe;

  int checks = 0;
  int errors = 0;
  logic [7:0] mCnt = 0, mDuty = 0, mCtrl = 0;

  always #4 clk = ~clk;

  fixperiod_pwm i_fixperiod_pwm (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .pinData(pinData), .pinOe(pinOe)
  );

  function automatic logic expOe(logic [7:0] c);
    return c[7];
  endfunction

  function automatic logic expPin(logic [7:0] c, logic [7:0] n, logic [7:0] d);
    return c[7] && (n <= d);
  endfunction

  function automatic logic [7:0] expRd(logic [7:0] a, logic [7:0] c, logic [7:0] d);
    if (a == 8'hD8) return d;
    if (a == 8'hD2) return c;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, sample after it
  task automatic cyc(logic tk, logic we, logic [7:0] a, logic [7:0] d, string req);
    @(negedge clk);
    tickIn = tk; wrEn = we; regAddr = a; wrData = d;
    @(posedge clk);
    if (we && a == 8'hD8) mDuty = d;
    if (we && a == 8'hD2) mCtrl = d;
    if (tk) mCnt = mCnt + 8'd1;
    #2;
    chk({req, " pinOe"}, {7'd0, pinOe}, {7'd0, expOe(mCtrl)});
    chk({req, " pinData"}, {7'd0, pinData}, {7'd0, expPin(mCtrl, mCnt, mDuty)});
    chk({req, " rdData"}, rdData, expRd(a, mCtrl, mDuty));
  endtask

  task automatic period_high(logic [7:0] duty, int expHigh, string req);
    int hi = 0;
    cyc(0, 1, 8'hD8, duty, req);
    while (mCnt != 0) cyc(1, 0, 8'hD8, 0, req);
    for (int i = 0; i < 256; i++) begin
      if (pinData) hi++;
      cyc(1, 0, 8'hD8, 0, req);
    end
    chk({req, " high steps"}, 8'(hi), 8'(expHigh));
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #2;
    // R9: reset state
    chk("R9 pinOe", {7'd0, pinOe}, 8'd0);
    chk("R9 pinData", {7'd0, pinData}, 8'd0);
    regAddr = 8'hD8; #1; chk("R9 duty", rdData, 8'h00);
    regAddr = 8'hD2; #1; chk("R9 ctrl", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;

    // R5: enable
    cyc(0, 1, 8'hD2, 8'h80, "R5");
    // R3: min and full duty; R2: mid duty
    period_high(8'd0, 1, "R3 min");
    period_high(8'd255, 256, "R3 full");
    period_high(8'd127, 128, "R2 mid");

    // R4: mid-period rewrites
    cyc(0, 1, 8'hD8, 8'd50, "R4");
    while (mCnt != 100) cyc(1, 0, 8'h00, 0, "R1");
    chk("R4 low before", {7'd0, pinData}, 8'd0);
    cyc(0, 1, 8'hD8, 8'd200, "R4 raise");
    chk("R4 high after raise", {7'd0, pinData}, 8'd1);
    cyc(0, 1, 8'hD8, 8'd10, "R4 drop");
    chk("R4 low after drop", {7'd0, pinData}, 8'd0);
    chk("R1 count kept", mCnt, 8'd100);

    // R7: storage bits only; R6: release
    cyc(0, 1, 8'hD2, 8'h7F, "R6");
    chk("R6 released", {7'd0, pinOe}, 8'd0);
    cyc(0, 0, 8'hD2, 0, "R7 readback");
    chk("R7 stored bits", rdData, 8'h7F);
    cyc(0, 1, 8'hD2, 8'hD5, "R7 with enable");
    // R8: stray address write ignored, reads 0
    cyc(0, 1, 8'hD3, 8'hFF, "R8 stray");
    chk("R8 stray read", rdData, 8'h00);
    cyc(0, 0, 8'hD8, 0, "R8 duty kept");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 3);
      a = (sel == 0) ? 8'hD8 : (sel == 1) ? 8'hD2 : 8'($urandom);
      cyc(1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0), a, 8'($urandom),
          "R2/R7/R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule